// File: doc/BRIEF.md
# Memory Error First/Next Capture Logger

This block sits beside an ECC checker and records the correctable (CE) and uncorrectable (UE) events it reports. Each class has two status flags. The "first" flag marks that an error of that class has been logged with full detail. The "next" flag marks that a further error of the same class arrived while that detail was still held. Only an error that finds its class's first flag clear records detail. For a CE that detail is the 4 KiB page number and a 16-bit syndrome. For a UE it is the page number alone.

A channel number is derived from the logged CE syndrome, which tells software which of two memory channels most likely held the failing data. Software reads the logs over a simple register port with one cycle of read latency. It clears status bits by writing ones to them. An interrupt line stays high while any status bit is set.

Register map (word address on `reg_addr`): 0 first status, 1 next status, 2 CE address log, 3 UE address log, 4 CE syndrome and channel. All other addresses read as zero.

Top module: `mem_err_logger`

## Requirements
- R1: After reset every status bit and log field is zero, `irq` is low and `reg_rdata` reads zero.
- R2: A CE event whose first bit is clear sets bit 0 of the first status register (address 0). In the same cycle it loads `ce_page` into bits 27:6 of the CE address log (address 2) and `ce_syn` into bits 15:0 of address 4. Bits 31:28 and 5:0 of every address log read zero.
- R3: A UE event whose first bit is clear sets bit 1 of the first status register and loads `ue_page` into bits 27:6 of the UE address log (address 3).
- R4: An event of a class whose first bit is already set sets that class's bit in the next status register (address 1: bit 0 CE, bit 1 UE). It leaves the logged address and syndrome unchanged.
- R5: When a class's first bit is clear but its next bit is set, a new event of that class sets the first bit and reloads its log fields, and the next bit stays set.
- R6: A write to address 0 or 1 clears each of bits 1:0 where the written data holds a one. All other written bits are ignored. Clears are applied before events of the same cycle, so an event in the clearing cycle is recorded against the cleared state.
- R7: A CE and a UE arriving in the same cycle are both recorded, each in its own class.
- R8: Bit 16 of address 4 gives the channel computed from the logged syndrome S. It is 0 if S[15:8] is zero, else 1 if S[7:0] is zero, else 0 if S[15:12] or S[11:8] is zero, else 1.
- R9: `irq` is a registered output that is high exactly while any first or next status bit is set. It changes in the same cycle as the status registers.
- R10: `reg_rdata` shows the register selected by `reg_addr` as it stood before the clock edge, one cycle after the address is presented. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_evt | input | 1 | Correctable error event, one cycle per event |
| ce_page | input | PAGE_W | 4 KiB page number of the correctable error |
| ce_syn | input | SYN_W | ECC syndrome of the correctable error |
| ue_evt | input | 1 | Uncorrectable error event, one cycle per event |
| ue_page | input | PAGE_W | 4 KiB page number of the uncorrectable error |
| reg_addr | input | ADDR_W | Register word address for read and write |
| reg_wr | input | 1 | Write strobe; ones in data clear status bits |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | High while any status bit is set |

## Verification
The embedded assertions watch the capture rules on every clock. An event always leaves its first bit set. A repeat event with the first bit held sets the next bit and keeps the log stable. A loading event stores exactly the presented payload. `irq` tracks the status registers, and unmapped reads return zero. The bench scenarios show what the properties cannot: how clears and events in the same cycle combine, whether both classes can be recorded at once, the channel mapping across syndrome shapes, and where the page and syndrome fields sit inside the readback words. All of these are compared cycle by cycle against a behavioural model.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int N_CLS  = 2;
  localparam int CLS_CE = 0;
  localparam int CLS_UE = 1;

  typedef enum logic [2:0] {
    RA_FIRST = 3'd0,
    RA_NEXT  = 3'd1,
    RA_CELOG = 3'd2,
    RA_UELOG = 3'd3,
    RA_SYN   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/errlog_capture.sv
module errlog_capture #(
  parameter int LOG_W = 38
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic [LOG_W-1:0] evt_log,
  input  logic             clr_first,
  input  logic             clr_next,
  output logic             first_q,
  output logic             next_q,
  output logic [LOG_W-1:0] log_q
);
  logic first_kept, next_kept;

  always_comb begin
    first_kept = first_q & ~clr_first;
    next_kept  = next_q  & ~clr_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b0;
      next_q  <= 1'b0;
      log_q   <= '0;
    end else if (evt) begin
      first_q <= 1'b1;
      if (first_kept) begin
        next_q <= 1'b1;
      end else begin
        next_q <= next_kept;
        log_q  <= evt_log;
      end
    end else begin
      first_q <= first_kept;
      next_q  <= next_kept;
    end
  end

  // R2
  evt_sets_first_chk: assert property (@(posedge clk) disable iff (rst)
    evt |=> first_q);

  // R4
  repeat_sets_next_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && first_q && !clr_first) |=> next_q);

  // R4
  repeat_keeps_log_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && first_q && !clr_first) |=> $stable(log_q));

  // R5
  load_takes_payload_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && !(first_q && !clr_first)) |=> (log_q == $past(evt_log)));
endmodule

// File: rtl/errlog_chan_sel.sv
module errlog_chan_sel #(
  parameter int SYN_W = 16
) (
  input  logic [SYN_W-1:0] syn,
  output logic             chan
);
  localparam int HALF = SYN_W / 2;
  localparam int QTR  = SYN_W / 4;

  logic hi_zero, lo_zero, q3_zero, q2_zero;

  always_comb begin
    hi_zero = (syn[SYN_W-1:HALF] == '0);
    lo_zero = (syn[HALF-1:0] == '0);
    q3_zero = (syn[SYN_W-1:SYN_W-QTR] == '0);
    q2_zero = (syn[SYN_W-QTR-1:HALF] == '0);
    if (hi_zero)               chan = 1'b0;
    else if (lo_zero)          chan = 1'b1;
    else if (q3_zero || q2_zero) chan = 1'b0;
    else                       chan = 1'b1;
  end
endmodule

// File: rtl/errlog_regport.sv
module errlog_regport
  import errlog_pkg::*;
#(
  parameter int PAGE_W   = 22,
  parameter int SYN_W    = 16,
  parameter int DATA_W   = 32,
  parameter int PAGE_LSB = 6,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CLS-1:0]  first_st,
  input  logic [N_CLS-1:0]  next_st,
  input  logic [PAGE_W-1:0] ce_page_log,
  input  logic [SYN_W-1:0]  ce_syn_log,
  input  logic              ce_chan,
  input  logic [PAGE_W-1:0] ue_page_log,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(RA_FIRST))      rd_mux[N_CLS-1:0] = first_st;
    else if (reg_addr == ADDR_W'(RA_NEXT))  rd_mux[N_CLS-1:0] = next_st;
    else if (reg_addr == ADDR_W'(RA_CELOG)) rd_mux[PAGE_LSB +: PAGE_W] = ce_page_log;
    else if (reg_addr == ADDR_W'(RA_UELOG)) rd_mux[PAGE_LSB +: PAGE_W] = ue_page_log;
    else if (reg_addr == ADDR_W'(RA_SYN)) begin
      rd_mux[SYN_W-1:0] = ce_syn_log;
      rd_mux[SYN_W]     = ce_chan;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // R10
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr > ADDR_W'(RA_SYN)) |=> (reg_rdata == '0));
endmodule

// File: rtl/mem_err_logger.sv
module mem_err_logger
  import errlog_pkg::*;
#(
  parameter int PAGE_W   = 22,
  parameter int SYN_W    = 16,
  parameter int DATA_W   = 32,
  parameter int PAGE_LSB = 6,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_evt,
  input  logic [PAGE_W-1:0] ce_page,
  input  logic [SYN_W-1:0]  ce_syn,
  input  logic              ue_evt,
  input  logic [PAGE_W-1:0] ue_page,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int LOG_W = PAGE_W + SYN_W;

  logic [N_CLS-1:0] evt, clr_first, clr_next, first_st, next_st;
  logic [LOG_W-1:0] log_in [N_CLS];
  logic [LOG_W-1:0] log_q  [N_CLS];
  logic             ce_chan;
  logic             irq_d;

  assign evt[CLS_CE]    = ce_evt;
  assign evt[CLS_UE]    = ue_evt;
  assign log_in[CLS_CE] = {ce_syn, ce_page};
  assign log_in[CLS_UE] = {{SYN_W{1'b0}}, ue_page};

  assign clr_first = (reg_wr && reg_addr == ADDR_W'(RA_FIRST)) ? reg_wdata[N_CLS-1:0] : '0;
  assign clr_next  = (reg_wr && reg_addr == ADDR_W'(RA_NEXT))  ? reg_wdata[N_CLS-1:0] : '0;

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    errlog_capture #(.LOG_W(LOG_W)) u_cap (
      .clk       (clk),
      .rst       (rst),
      .evt       (evt[c]),
      .evt_log   (log_in[c]),
      .clr_first (clr_first[c]),
      .clr_next  (clr_next[c]),
      .first_q   (first_st[c]),
      .next_q    (next_st[c]),
      .log_q     (log_q[c])
    );
  end

  errlog_chan_sel #(.SYN_W(SYN_W)) u_chan (
    .syn  (log_q[CLS_CE][LOG_W-1:PAGE_W]),
    .chan (ce_chan)
  );

  errlog_regport #(
    .PAGE_W(PAGE_W), .SYN_W(SYN_W), .DATA_W(DATA_W),
    .PAGE_LSB(PAGE_LSB), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .first_st    (first_st),
    .next_st     (next_st),
    .ce_page_log (log_q[CLS_CE][PAGE_W-1:0]),
    .ce_syn_log  (log_q[CLS_CE][LOG_W-1:PAGE_W]),
    .ce_chan     (ce_chan),
    .ue_page_log (log_q[CLS_UE][PAGE_W-1:0]),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata)
  );

  // Any event, or any status bit that survives this cycle's clears, holds irq.
  assign irq_d = (|evt) | (|(first_st & ~clr_first)) | (|(next_st & ~clr_next));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_d;
  end

  // R9
  irq_tracks_status_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|{first_st, next_st}));

  // R7
  both_classes_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_evt && ue_evt) |=> (first_st == '1));
endmodule

// File: tb/sim_mem_err_logger.sv
module sim_mem_err_logger;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_evt = 1'b0, ue_evt = 1'b0, reg_wr = 1'b0;
  logic [21:0] ce_page = '0, ue_page = '0;
  logic [15:0] ce_syn = '0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  always #5 clk = ~clk;

  mem_err_logger u0 (
    .clk(clk), .rst(rst), .ce_evt(ce_evt), .ce_page(ce_page), .ce_syn(ce_syn),
    .ue_evt(ue_evt), .ue_page(ue_page), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural model state
  int m_first[2], m_next[2];
  int m_cepage, m_cesyn, m_uepage;
  logic [31:0] exp_rdata;
  logic        exp_irq;
  int checks = 0, failures = 0;
  bit done = 0;
  string tag;

  function automatic int chan_of(int s);
    int hi = (s >> 8) & 255;
    int lo = s & 255;
    if (hi == 0) return 0;
    if (lo == 0) return 1;
    if ((hi >> 4) == 0 || (hi % 16) == 0) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] model_read(int a);
    logic [31:0] v = 32'd0;
    case (a)
      0: v = 32'(m_first[0] + 2 * m_first[1]);
      1: v = 32'(m_next[0] + 2 * m_next[1]);
      2: v = 32'(m_cepage) << 6;
      3: v = 32'(m_uepage) << 6;
      4: v = 32'(m_cesyn) | (32'(chan_of(m_cesyn)) << 16);
      default: v = 32'd0;
    endcase
    return v;
  endfunction

  task automatic model_class(int c, bit e, bit cf, bit cn, int page, int syn);
    if (cf) m_first[c] = 0;
    if (cn) m_next[c] = 0;
    if (e) begin
      if (m_first[c] != 0) m_next[c] = 1;
      else begin
        m_first[c] = 1;
        if (c == 0) begin m_cepage = page; m_cesyn = syn; end
        else m_uepage = page;
      end
    end
  endtask

  // Drive one cycle at the falling edge, advance the model, compare at the next falling edge.
  task automatic step(input bit r, input bit ce, input int cp, input int cs,
                      input bit ue, input int up, input bit wr, input int a,
                      input int wd, input string t);
    tag = t;
    rst = r; ce_evt = ce; ce_page = 22'(cp); ce_syn = 16'(cs);
    ue_evt = ue; ue_page = 22'(up); reg_wr = wr; reg_addr = 3'(a); reg_wdata = 32'(wd);
    if (r) begin
      m_first = '{0, 0}; m_next = '{0, 0};
      m_cepage = 0; m_cesyn = 0; m_uepage = 0;
      exp_rdata = 32'd0;
    end else begin
      exp_rdata = model_read(a);
      model_class(0, ce, wr && a == 0 && wd[0], wr && a == 1 && wd[0], cp, cs);
      model_class(1, ue, wr && a == 0 && wd[1], wr && a == 1 && wd[1], up, 0);
    end
    exp_irq = (m_first[0] | m_first[1] | m_next[0] | m_next[1]) != 0;
    @(negedge clk);
    checks++;
    if (reg_rdata !== exp_rdata) begin
      failures++;
      $display("FAIL %s rdata got %h exp %h", tag, reg_rdata, exp_rdata);
    end
    checks++;
    if (irq !== exp_irq) begin
      failures++;
      $display("FAIL %s R9 irq got %b exp %b", tag, irq, exp_irq);
    end
  endtask

  task automatic rd(int a, string t);
    step(0, 0, 0, 0, 0, 0, 0, a, 0, t);
  endtask

  task automatic wr1c(int a, int d, string t);
    step(0, 0, 0, 0, 0, 0, 1, a, d, t);
  endtask

  task automatic ce_at(int p, int s, int a, string t);
    step(0, 1, p, s, 0, 0, 0, a, 0, t);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
    for (int a = 0; a < 8; a++) rd(a, "R1 reset state");

    ce_at(22'h03ABCD, 16'h00A5, 0, "R2 first CE");
    rd(0, "R2 first status"); rd(2, "R2 CE address log"); rd(4, "R2 syndrome");

    ce_at(22'h000111, 16'hFFFF, 2, "R4 repeat CE");
    rd(1, "R4 next status"); rd(2, "R4 CE log held"); rd(4, "R4 syndrome held");

    step(0, 0, 0, 0, 1, 22'h3FFFFF, 0, 3, 0, "R3 first UE");
    rd(0, "R3 first status"); rd(3, "R3 UE log max page");
    step(0, 0, 0, 0, 1, 22'h000001, 0, 3, 0, "R4 repeat UE");
    rd(1, "R4 UE next"); rd(3, "R4 UE log held");

    wr1c(0, 32'hFFFF_FFFC, "R6 ignored bits"); rd(0, "R6 status intact");
    wr1c(0, 1, "R6 clear CE first"); rd(0, "R6 after clear"); rd(1, "R6 next kept");
    ce_at(22'h155555, 16'h1200, 0, "R5 reload CE");
    rd(2, "R5 CE log reloaded"); rd(4, "R5 R8 syndrome chan"); rd(1, "R5 next stays");

    wr1c(1, 3, "R6 clear next"); wr1c(0, 3, "R6 clear first");
    rd(0, "R9 all clear"); rd(1, "R9 all clear next");

    step(0, 1, 22'h00F0F0, 16'h0F11, 1, 22'h2AAAAA, 0, 0, 0, "R7 both classes");
    rd(0, "R7 both first"); rd(2, "R7 CE log"); rd(3, "R7 UE log"); rd(4, "R7 R8 chan");

    // R6: clear and event in the same cycle, event recorded against cleared state
    step(0, 1, 22'h0000AB, 16'hF011, 0, 0, 1, 0, 1, "R6 clear with event");
    rd(0, "R6 first set again"); rd(1, "R6 no next"); rd(2, "R6 log reloaded"); rd(4, "R8 F011");

    // R8 channel decode across syndrome shapes
    begin
      int syns[6] = '{16'h0000, 16'h1200, 16'h1234, 16'hFFFF, 16'h0F11, 16'h8001};
      foreach (syns[k]) begin
        wr1c(0, 1, "R8 clear");
        ce_at(k + 7, syns[k], 4, "R8 load");
        rd(4, "R8 channel");
      end
    end

    for (int a = 5; a < 8; a++) rd(a, "R10 unmapped");
    wr1c(1, 3, "R10 wr unmapped prep");
    step(0, 0, 0, 0, 0, 0, 1, 6, 3, "R10 write unmapped ignored");
    rd(0, "R10 status after unmapped write");

    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 mid reset");
    rd(2, "R1 log cleared"); rd(0, "R1 status cleared");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule